// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block sequences descriptor fetches for one side of a DMA channel. Software supplies a first descriptor pointer, a layout selection and a descriptor count. It then pulses the channel enable. The walker reads each descriptor one 32-bit word at a time over a request/response read port. It assembles the buffer address, byte size and control word of each descriptor and offers them to the data engine on a valid/ready handoff. It then waits for the engine to report that the transfer for that descriptor has finished, and only then moves on to the next descriptor.

Two layouts are supported. In the packed layout, descriptors sit back to back 16 bytes apart. In the chained layout, each 32-byte descriptor carries a 64-bit pointer to the next one. A descriptor can ask the walker to stop in a paused state once its transfer is finished; a resume command then continues the walk. The walk ends when the count runs out, when a descriptor is marked as the final one, when a read returns an error, or when a disable command is given. The address of the descriptor in hand is visible as two 32-bit halves for status readback.

Top module: `dsc_walker`

## Requirements
- R1: After reset, ch_state is 0 (idle), ch_enable is 0, and rd_req_valid, dsc_valid, done_pulse and err_pulse are 0. cur_dsc_lo and cur_dsc_hi are 0.
- R2: An idle cmd_enable pulse latches cfg_start_ptr as the current descriptor address, sets ch_state to 1 (busy) and ch_enable to 1. ch_enable stays 1 while busy or paused and clears by itself when the walk ends.
- R3: With cfg_linked=0, each descriptor is read as 4 words at byte offsets +0 (address bits 31:0), +4 (address bits 63:32), +8 (size) and +12 (control). The next descriptor is at current address + 16.
- R4: With cfg_linked=1, each descriptor is read as 6 words: the same 4 words, then +16 (next pointer bits 31:0) and +20 (next pointer bits 63:32). The next descriptor is fetched from that pointer. The reserved words at +24 and +28 are never read.
- R5: At most one read is outstanding. rd_req_valid, once raised, stays high with rd_req_addr unchanged until rd_req_ready is seen.
- R6: Each descriptor is offered on dsc_addr/dsc_size/dsc_ctrl with dsc_valid held, and the fields stable, until dsc_ready. A size of zero is offered unchanged and is not skipped.
- R7: A descriptor counts as processed when xfer_done is seen after its handoff. After cfg_count descriptors have been processed, done_pulse is high for one cycle and the channel returns to idle. A count of zero gives done_pulse with no read at all.
- R8: Control bit 1 (final) ends the walk, with done_pulse, once that descriptor is processed, even if the count has not run out.
- R9: Control bit 0 (pause) moves the channel to ch_state 2 (paused) once that descriptor is processed. In this state no read and no handoff is made, and the current descriptor address shows the next descriptor. cmd_resume continues the walk from there. Running out of the count or bit 1 takes priority over a pause.
- R10: A read response with rd_rsp_err set aborts the walk: err_pulse is high for one cycle, the channel returns to idle, no done_pulse is given and no further descriptor is offered.
- R11: cmd_disable forces the channel to idle from any state on the next cycle, with no done_pulse. A response still in flight is then ignored.
- R12: cur_dsc_lo and cur_dsc_hi give bits 31:0 and 63:32 of the address of the descriptor being fetched or handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_ptr | input | 64 | Address of the first descriptor |
| cfg_linked | input | 1 | 0 packed layout, 1 chained layout |
| cfg_count | input | 16 | Number of descriptors to process |
| cmd_enable | input | 1 | Start pulse, taken only when idle |
| cmd_disable | input | 1 | Forces the channel to idle |
| cmd_resume | input | 1 | Leaves the paused state |
| rd_req_valid | output | 1 | Word read request |
| rd_req_addr | output | 64 | Byte address of the requested word |
| rd_req_ready | input | 1 | Read request accepted |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Returned word |
| rd_rsp_err | input | 1 | Returned word is in error |
| dsc_valid | output | 1 | Descriptor offered to the data engine |
| dsc_addr | output | 64 | Buffer address of the descriptor |
| dsc_size | output | 32 | Byte size of the descriptor |
| dsc_ctrl | output | 32 | Control word of the descriptor |
| dsc_ready | input | 1 | Data engine takes the descriptor |
| xfer_done | input | 1 | Data engine finished the taken descriptor |
| ch_state | output | 2 | 0 idle, 1 busy, 2 paused |
| ch_enable | output | 1 | Enable bit, clears itself at the end of the walk |
| cur_dsc_lo | output | 32 | Current descriptor address bits 31:0 |
| cur_dsc_hi | output | 32 | Current descriptor address bits 63:32 |
| done_pulse | output | 1 | One-cycle end-of-walk event |
| err_pulse | output | 1 | One-cycle read-error event |

## Verification
A wrong word index or wrong stride inside the fetch sequencer shows up in the next handoff. The offered descriptor fields no longer match the memory contents, and the number of reads per descriptor differs from 4 or 6. A stale or miscounted remaining count shows as a missing, extra or early done_pulse at the end of the list. A wrong phase shows within a cycle or two of the triggering event as a ch_state value that does not match, or as reads or handoffs made while paused or after a disable. A lost next pointer shows as the chained walk offering a descriptor out of list order on the very next handoff.

// File: rtl/dw_pkg.sv
package dw_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_BUSY   = 2'd1,
    CH_PAUSED = 2'd2
  } ch_state_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_HAND,
    PH_XFER,
    PH_PAUSE
  } phase_e;

  localparam int CTRL_PAUSE_BIT = 0;
  localparam int CTRL_FINAL_BIT = 1;
  localparam int PACKED_WORDS   = 4;
  localparam int CHAINED_WORDS  = 6;
  localparam int PACKED_STRIDE  = 16;
endpackage

// File: rtl/dw_fetch.sv
// Word-by-word descriptor reader: one outstanding request, words stored by index.
module dw_fetch #(
  parameter int AW   = 64,
  parameter int DW   = 32,
  parameter int MAXW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                abort,
  input  logic [AW-1:0]       base,
  input  logic [$clog2(MAXW+1)-1:0] nwords,
  output logic                rd_req_valid,
  output logic [AW-1:0]       rd_req_addr,
  input  logic                rd_req_ready,
  input  logic                rd_rsp_valid,
  input  logic [DW-1:0]       rd_rsp_data,
  input  logic                rd_rsp_err,
  output logic                fetch_done,
  output logic                fetch_err,
  output logic [MAXW*DW-1:0]  words
);
  localparam int IW  = $clog2(MAXW+1);
  localparam int BPW = DW / 8;

  logic          active;
  logic          waiting;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nxt;
  logic [AW-1:0] base_q;
  logic [DW-1:0] wbuf [MAXW];
  logic          take_rsp;

  assign idx_nxt  = idx + IW'(1);
  assign take_rsp = active && waiting && rd_rsp_valid && !abort && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      active       <= 1'b0;
      waiting      <= 1'b0;
      idx          <= '0;
      base_q       <= '0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      fetch_done   <= 1'b0;
      fetch_err    <= 1'b0;
    end else begin
      fetch_done <= 1'b0;
      fetch_err  <= 1'b0;
      if (abort) begin
        active       <= 1'b0;
        waiting      <= 1'b0;
        rd_req_valid <= 1'b0;
      end else if (start) begin
        active       <= 1'b1;
        waiting      <= 1'b0;
        idx          <= '0;
        base_q       <= base;
        rd_req_valid <= 1'b1;
        rd_req_addr  <= base;
      end else if (active) begin
        if (rd_req_valid && rd_req_ready) begin
          rd_req_valid <= 1'b0;
          waiting      <= 1'b1;
        end
        if (take_rsp) begin
          waiting <= 1'b0;
          if (rd_rsp_err) begin
            active    <= 1'b0;
            fetch_err <= 1'b1;
          end else if (idx_nxt == nwords) begin
            active     <= 1'b0;
            fetch_done <= 1'b1;
          end else begin
            idx          <= idx_nxt;
            rd_req_valid <= 1'b1;
            rd_req_addr  <= base_q + AW'(idx_nxt) * AW'(BPW);
          end
        end
      end
    end
  end

  // Word store kept free of reset so it maps onto plain storage.
  always_ff @(posedge clk) begin
    if (take_rsp && !rd_rsp_err) begin
      wbuf[idx] <= rd_rsp_data;
    end
  end

  for (genvar g = 0; g < MAXW; g++) begin : g_pack
    assign words[g*DW +: DW] = wbuf[g];
  end
endmodule

// File: rtl/dw_seq.sv
// Walk sequencer: phases, descriptor count, pause points and next-address choice.
module dw_seq
  import dw_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] start_ptr,
  input  logic          linked,
  input  logic [CW-1:0] count,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          cmd_resume,
  input  logic          fetch_done,
  input  logic          fetch_err,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_size,
  input  logic [DW-1:0] f_ctrl,
  input  logic [AW-1:0] f_next,
  output logic          f_start,
  output logic [IW-1:0] f_nwords,
  output logic          dsc_valid,
  output logic [AW-1:0] dsc_addr,
  output logic [DW-1:0] dsc_size,
  output logic [DW-1:0] dsc_ctrl,
  input  logic          dsc_ready,
  input  logic          xfer_done,
  output ch_state_e     state,
  output logic [AW-1:0] cur_addr,
  output logic          done_pulse,
  output logic          err_pulse
);
  phase_e        phase;
  logic          linked_q;
  logic [CW-1:0] remaining;
  logic [AW-1:0] next_q;
  logic          ends_here;

  assign f_nwords  = linked_q ? IW'(CHAINED_WORDS) : IW'(PACKED_WORDS);
  assign ends_here = dsc_ctrl[CTRL_FINAL_BIT] || (remaining == CW'(1));

  always_comb begin
    case (phase)
      PH_IDLE:  state = CH_IDLE;
      PH_PAUSE: state = CH_PAUSED;
      default:  state = CH_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      linked_q   <= 1'b0;
      remaining  <= '0;
      next_q     <= '0;
      cur_addr   <= '0;
      f_start    <= 1'b0;
      dsc_valid  <= 1'b0;
      dsc_addr   <= '0;
      dsc_size   <= '0;
      dsc_ctrl   <= '0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      f_start    <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      if (cmd_disable) begin
        phase     <= PH_IDLE;
        dsc_valid <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            if (cmd_enable) begin
              linked_q  <= linked;
              remaining <= count;
              cur_addr  <= start_ptr;
              if (count == '0) begin
                done_pulse <= 1'b1;
              end else begin
                phase   <= PH_FETCH;
                f_start <= 1'b1;
              end
            end
          end
          PH_FETCH: begin
            if (fetch_err) begin
              err_pulse <= 1'b1;
              phase     <= PH_IDLE;
            end else if (fetch_done) begin
              dsc_addr  <= f_addr;
              dsc_size  <= f_size;
              dsc_ctrl  <= f_ctrl;
              dsc_valid <= 1'b1;
              next_q    <= linked_q ? f_next : cur_addr + AW'(PACKED_STRIDE);
              phase     <= PH_HAND;
            end
          end
          PH_HAND: begin
            if (dsc_ready) begin
              dsc_valid <= 1'b0;
              phase     <= PH_XFER;
            end
          end
          PH_XFER: begin
            if (xfer_done) begin
              remaining <= remaining - CW'(1);
              if (ends_here) begin
                done_pulse <= 1'b1;
                phase      <= PH_IDLE;
              end else begin
                cur_addr <= next_q;
                if (dsc_ctrl[CTRL_PAUSE_BIT]) begin
                  phase <= PH_PAUSE;
                end else begin
                  phase   <= PH_FETCH;
                  f_start <= 1'b1;
                end
              end
            end
          end
          PH_PAUSE: begin
            if (cmd_resume) begin
              phase   <= PH_FETCH;
              f_start <= 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsc_walker.sv
module dsc_walker
  import dw_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_start_ptr,
  input  logic          cfg_linked,
  input  logic [CW-1:0] cfg_count,
  input  logic          cmd_enable,
  input  logic          cmd_disable,
  input  logic          cmd_resume,
  output logic          rd_req_valid,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_req_ready,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  input  logic          rd_rsp_err,
  output logic          dsc_valid,
  output logic [AW-1:0] dsc_addr,
  output logic [DW-1:0] dsc_size,
  output logic [DW-1:0] dsc_ctrl,
  input  logic          dsc_ready,
  input  logic          xfer_done,
  output logic [1:0]    ch_state,
  output logic          ch_enable,
  output logic [DW-1:0] cur_dsc_lo,
  output logic [DW-1:0] cur_dsc_hi,
  output logic          done_pulse,
  output logic          err_pulse
);
  localparam int MAXW = CHAINED_WORDS;
  localparam int IW   = $clog2(MAXW+1);

  logic              f_start;
  logic [IW-1:0]     f_nwords;
  logic              f_done;
  logic              f_err;
  logic [MAXW*DW-1:0] f_words;
  logic [AW-1:0]     cur_addr;
  ch_state_e         st;

  dw_fetch #(.AW(AW), .DW(DW), .MAXW(MAXW)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .start        (f_start),
    .abort        (cmd_disable),
    .base         (cur_addr),
    .nwords       (f_nwords),
    .rd_req_valid (rd_req_valid),
    .rd_req_addr  (rd_req_addr),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .rd_rsp_err   (rd_rsp_err),
    .fetch_done   (f_done),
    .fetch_err    (f_err),
    .words        (f_words)
  );

  dw_seq #(.AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_ptr   (cfg_start_ptr),
    .linked      (cfg_linked),
    .count       (cfg_count),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .cmd_resume  (cmd_resume),
    .fetch_done  (f_done),
    .fetch_err   (f_err),
    .f_addr      (f_words[2*DW-1:0]),
    .f_size      (f_words[3*DW-1:2*DW]),
    .f_ctrl      (f_words[4*DW-1:3*DW]),
    .f_next      (f_words[6*DW-1:4*DW]),
    .f_start     (f_start),
    .f_nwords    (f_nwords),
    .dsc_valid   (dsc_valid),
    .dsc_addr    (dsc_addr),
    .dsc_size    (dsc_size),
    .dsc_ctrl    (dsc_ctrl),
    .dsc_ready   (dsc_ready),
    .xfer_done   (xfer_done),
    .state       (st),
    .cur_addr    (cur_addr),
    .done_pulse  (done_pulse),
    .err_pulse   (err_pulse)
  );

  assign ch_state   = st;
  assign ch_enable  = (st != CH_IDLE);
  assign cur_dsc_lo = cur_addr[DW-1:0];
  assign cur_dsc_hi = cur_addr[2*DW-1:DW];
endmodule

// File: rtl/dsc_walker_chk.sv
module dsc_walker_chk #(
  parameter int AW = 64,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_disable,
  input logic          rd_req_valid,
  input logic [AW-1:0] rd_req_addr,
  input logic          rd_req_ready,
  input logic          dsc_valid,
  input logic [AW-1:0] dsc_addr,
  input logic [DW-1:0] dsc_size,
  input logic          dsc_ready,
  input logic [1:0]    ch_state,
  input logic          done_pulse,
  input logic          err_pulse
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready && !cmd_disable |=> rd_req_valid && $stable(rd_req_addr)); // R5
  AST_DSC_HOLD: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && !dsc_ready && !cmd_disable |=> dsc_valid && $stable(dsc_addr) && $stable(dsc_size)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ch_state == 2'd0); // R7
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> ch_state == 2'd0 && !done_pulse); // R10
  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_disable |=> ch_state == 2'd0 && !done_pulse); // R11
  AST_QUIET_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    ch_state != 2'd1 |-> !rd_req_valid && !dsc_valid); // R9
endmodule

bind dsc_walker dsc_walker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_disable  (cmd_disable),
  .rd_req_valid (rd_req_valid),
  .rd_req_addr  (rd_req_addr),
  .rd_req_ready (rd_req_ready),
  .dsc_valid    (dsc_valid),
  .dsc_addr     (dsc_addr),
  .dsc_size     (dsc_size),
  .dsc_ready    (dsc_ready),
  .ch_state     (ch_state),
  .done_pulse   (done_pulse),
  .err_pulse    (err_pulse)
);

// File: tb/dsc_walker_test.sv
`timescale 1ns/1ps
module dsc_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] cfg_start_ptr = '0;
  logic        cfg_linked = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_resume = 1'b0;
  logic        rd_req_valid;
  logic [63:0] rd_req_addr;
  logic        rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic        dsc_valid;
  logic [63:0] dsc_addr;
  logic [31:0] dsc_size, dsc_ctrl;
  logic        dsc_ready = 1'b0;
  logic        xfer_done = 1'b0;
  logic [1:0]  ch_state;
  logic        ch_enable;
  logic [31:0] cur_dsc_lo, cur_dsc_hi;
  logic        done_pulse, err_pulse;

  always #10 clk = ~clk;

  dsc_walker uut (.*);

  int checks = 0, failures = 0;
  logic [31:0] mem [0:1023];
  logic [63:0] e_loc [0:15];
  logic [63:0] e_addr [0:15];
  logic [31:0] e_size [0:15];
  logic [31:0] e_ctrl [0:15];
  logic [63:0] g_addr [0:31];
  logic [31:0] g_size [0:31];
  logic [31:0] g_ctrl [0:31];
  int ngot = 0, nreads = 0, ndone = 0, nerr = 0;
  bit err_armed = 0;
  logic [63:0] err_at = '0;
  localparam logic [63:0] BASE = 64'h0000_0001_0000_0100;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read port responder
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [63:0] paddr = '0;
    void'($urandom(32'd4021));
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      rd_rsp_err = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data = mem[paddr[11:2]];
          rd_rsp_err = err_armed && (paddr == err_at);
          pend = 0;
        end else dly--;
      end
      rd_req_ready = ($urandom % 4) != 0;
      if (rd_req_valid && rd_req_ready) begin
        pend = 1;
        paddr = rd_req_addr;
        dly = $urandom % 3;
        nreads++;
      end
    end
  end

  // data engine model and event counters
  initial begin
    bit xp = 0;
    int xd = 0;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (done_pulse) ndone++;
      if (err_pulse) nerr++;
      if (xp) begin
        if (xd == 0) begin xfer_done = 1'b1; xp = 0; end else xd--;
      end
      dsc_ready = ($urandom % 3) != 0;
      if (dsc_valid && dsc_ready) begin
        if (ngot < 32) begin
          g_addr[ngot] = dsc_addr; g_size[ngot] = dsc_size; g_ctrl[ngot] = dsc_ctrl;
        end
        ngot++;
        xp = 1;
        xd = $urandom % 4;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 150000);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic gen_list(input bit linked, input int n);
    for (int i = 0; i < n; i++) begin
      e_loc[i]  = linked ? BASE + 64'(32 * (n - 1 - i)) : BASE + 64'(16 * i);
      e_addr[i] = {$urandom, $urandom};
      e_size[i] = $urandom;
      e_ctrl[i] = {$urandom} & 32'hFFFF_FFFC;
    end
  endtask

  task automatic store_list(input bit linked, input int n);
    for (int i = 0; i < n; i++) begin
      int w;
      w = int'(e_loc[i][11:2]);
      mem[w] = e_addr[i][31:0];
      mem[w+1] = e_addr[i][63:32];
      mem[w+2] = e_size[i];
      mem[w+3] = e_ctrl[i];
      if (linked) begin
        logic [63:0] nx;
        nx = (i + 1 < n) ? e_loc[i+1] : 64'h0;
        mem[w+4] = nx[31:0];
        mem[w+5] = nx[63:32];
      end
    end
  endtask

  task automatic start(input bit linked, input int cnt);
    ngot = 0; nreads = 0; ndone = 0; nerr = 0;
    cfg_linked = linked;
    cfg_count = 16'(cnt);
    cfg_start_ptr = e_loc[0];
    @(negedge clk); cmd_enable = 1'b1;
    @(negedge clk); cmd_enable = 1'b0;
  endtask

  task automatic wait_state(input logic [1:0] s, input string tag);
    int t = 0;
    while (ch_state != s && t < 4000) begin @(negedge clk); t++; end
    chk(t < 4000, tag, 64'(ch_state), 64'(s));
  endtask

  task automatic cmp_list(input int k, input bit linked, input string tag);
    chk(ngot == k, {tag, " handoff count"}, 64'(ngot), 64'(k));
    for (int i = 0; i < k && i < ngot; i++) begin
      chk(g_addr[i] == e_addr[i] && g_size[i] == e_size[i] && g_ctrl[i] == e_ctrl[i],
          {tag, " descriptor fields"}, g_addr[i] ^ 64'(g_size[i]), e_addr[i] ^ 64'(e_size[i]));
    end
    chk(nreads == k * (linked ? 6 : 4), {tag, " word reads"}, 64'(nreads), 64'(k * (linked ? 6 : 4)));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ch_state == 0 && !ch_enable && !rd_req_valid && !dsc_valid, "R1 reset outputs",
        {ch_state, ch_enable, rd_req_valid, dsc_valid}, 0);
    chk(cur_dsc_lo == 0 && cur_dsc_hi == 0 && !done_pulse && !err_pulse, "R1 reset address",
        {cur_dsc_hi, cur_dsc_lo}, 0);

    // R2 R3 R12 packed list
    gen_list(0, 3); store_list(0, 3);
    start(0, 3);
    chk(ch_state == 1 && ch_enable, "R2 busy after enable", {ch_state, ch_enable}, 3);
    chk({cur_dsc_hi, cur_dsc_lo} == e_loc[0], "R12 current address halves", {cur_dsc_hi, cur_dsc_lo}, e_loc[0]);
    wait_state(0, "R2 walk finishes");
    chk(!ch_enable, "R2 enable self-clears", 64'(ch_enable), 0);
    cmp_list(3, 0, "R3 packed");
    chk(ndone == 1, "R7 one done pulse", 64'(ndone), 1);

    // R4 chained list, stored in reverse order
    gen_list(1, 4); store_list(1, 4);
    start(1, 4);
    wait_state(0, "R4 walk finishes");
    cmp_list(4, 1, "R4 chained");
    chk(ndone == 1 && nerr == 0, "R7 chained done", 64'(ndone), 1);

    // R8 final bit ends walk early
    gen_list(1, 5); e_ctrl[2] |= 32'h2; store_list(1, 5);
    start(1, 5);
    wait_state(0, "R8 walk finishes");
    cmp_list(3, 1, "R8 final bit");
    chk(ndone == 1, "R8 done pulse", 64'(ndone), 1);

    // R6 size zero is handed on
    gen_list(0, 3); e_size[1] = 0; store_list(0, 3);
    start(0, 3);
    wait_state(0, "R6 walk finishes");
    cmp_list(3, 0, "R6 zero size");

    // R7 count zero
    start(0, 0);
    repeat (10) @(negedge clk);
    chk(ndone == 1 && nreads == 0 && ngot == 0, "R7 zero count", {32'(ndone), 32'(nreads)}, {32'd1, 32'd0});

    // R9 pause and resume
    gen_list(0, 3); e_ctrl[0] |= 32'h1; store_list(0, 3);
    start(0, 3);
    wait_state(2, "R9 reaches paused");
    chk(ngot == 1 && ch_enable, "R9 one descriptor before pause", 64'(ngot), 1);
    chk({cur_dsc_hi, cur_dsc_lo} == e_loc[1], "R9 R12 address shows next", {cur_dsc_hi, cur_dsc_lo}, e_loc[1]);
    repeat (20) @(negedge clk);
    chk(ngot == 1 && nreads == 4 && ch_state == 2, "R9 quiet while paused", {32'(ngot), 32'(nreads)}, {32'd1, 32'd4});
    cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0;
    wait_state(0, "R9 walk finishes after resume");
    cmp_list(3, 0, "R9 resumed");
    chk(ndone == 1, "R9 done after resume", 64'(ndone), 1);

    // R9 pause on the final descriptor: end wins
    gen_list(1, 2); e_ctrl[1] |= 32'h1; store_list(1, 2);
    start(1, 2);
    wait_state(0, "R9 end over pause");
    chk(ndone == 1 && ngot == 2, "R9 end takes priority", 64'(ndone), 1);

    // R10 error response
    gen_list(1, 3); store_list(1, 3);
    err_at = e_loc[1] + 64'd8; err_armed = 1;
    start(1, 3);
    wait_state(0, "R10 walk aborts");
    repeat (5) @(negedge clk);
    err_armed = 0;
    chk(nerr == 1 && ndone == 0 && ngot == 1, "R10 abort on error", {32'(nerr), 32'(ngot)}, {32'd1, 32'd1});

    // R11 disable mid walk
    gen_list(0, 4); store_list(0, 4);
    start(0, 4);
    begin
      int t = 0;
      while (ngot < 1 && t < 4000) begin @(negedge clk); t++; end
    end
    cmd_disable = 1'b1; @(negedge clk); cmd_disable = 1'b0;
    chk(ch_state == 0 && !ch_enable, "R11 idle after disable", 64'(ch_state), 0);
    begin
      int snap;
      snap = ngot;
      repeat (20) @(negedge clk);
      chk(ngot == snap && ndone == 0 && ch_state == 0, "R11 no activity after disable", 64'(ngot), 64'(snap));
    end

    // random lists
    for (int r = 0; r < 8; r++) begin
      bit lk;
      int n;
      lk = 1'($urandom);
      n = 1 + int'($urandom % 8);
      gen_list(lk, n); store_list(lk, n);
      start(lk, n);
      wait_state(0, "R3 R4 random walk finishes");
      cmp_list(n, lk, lk ? "R4 random" : "R3 random");
      chk(ndone == 1, "R7 random done", 64'(ndone), 1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule